// File: doc/BRIEF.md
# Johnson Counter Timing Generator

This block produces a repeating set of non-overlapping timing phases from a switched-tail shift register of `STAGES` flip-flops. On each enabled clock, the stages shift by one position. The first stage takes in the inverse of the last stage. This gives a cycle of `2*STAGES` distinct register patterns. Each pattern is decoded by a single two-input AND into its own phase line, so a controller can sequence `2*STAGES` operations without a binary counter or a wide decoder.

The register steps only while enable is high and holds otherwise. A synchronous clear returns it to the all-zero pattern. An asynchronous active-low reset does the same. A register with N stages has `2^N` patterns, but only `2*STAGES` belong to the cycle. If the register ever lands on any other pattern, a detector flags it and the next enabled clock loads the all-zero pattern. The register can therefore never settle into a false cycle. The phase lines are held low while the register is off the cycle.

Top module: `johnson_timing_gen`

## Requirements
- R1: On a clock with `en_i`=1 and `clr_i`=0 from a valid pattern, `stage_o[0]` becomes the inverse of the previous `stage_o[STAGES-1]`, and `stage_o[i]` becomes the previous `stage_o[i-1]` for i from 1 to STAGES-1.
- R2: From the all-zero pattern, `2*STAGES` enabled clocks return the register to all-zero. The patterns passed through are all distinct. Step k (0 to 2*STAGES-1) has bits 0..k-1 set for k<=STAGES, and bits k-STAGES..STAGES-1 set for larger k.
- R3: `tick_o[k]` is high exactly in step k. Bit 0 decodes "first and last stage both 0". Bit STAGES decodes "first and last both 1". Bit k in 1..STAGES-1 decodes stage[k-1]=1 with stage[k]=0. Bit STAGES+k decodes stage[k-1]=0 with stage[k]=1.
- R4: In every valid pattern exactly one bit of `tick_o` is high. In any other pattern all bits are low.
- R5: While `en_i`=0 and `clr_i`=0, `stage_o` and `tick_o` keep their values.
- R6: `clr_i`=1 loads the all-zero pattern on the next clock, whatever the value of `en_i`.
- R7: While `rst_ni` is low, `stage_o` is all-zero and `tick_o` equals 1 (bit 0 high), with no clock needed.
- R8: If the register holds a pattern outside the valid set and `en_i`=1, the next clock loads the all-zero pattern. With `en_i`=0, the pattern is held.
- R9: The valid set is exactly the `2*STAGES` patterns that have at most one place where neighbouring stages differ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously by the chip |
| en_i | input | 1 | Step enable |
| clr_i | input | 1 | Synchronous clear to all-zero, overrides enable |
| stage_o | output | STAGES | Raw register stages, bit 0 is the first stage |
| tick_o | output | 2*STAGES | One-hot timing phases |

## Verification
The bench runs the register through several full cycles, with stalls placed at every phase and clears applied both mid-cycle and together with enable. A design that wires the feedback without the inversion would stick at all-zero or all-ones. A design with a swapped decode pair would light the wrong phase line. A clear that yields to enable would take one step instead of returning to zero.

The next-state logic is also tried on all `2^STAGES` patterns. This covers the misfit patterns that the register cannot reach from reset. If detection were missing, a pattern such as 0101 would keep circulating. If the validity test were wrong, the count of accepted patterns would differ from `2*STAGES`.

// File: rtl/johnson_pkg.sv
package johnson_pkg;

  // Source selected for the next register value.
  typedef enum logic [1:0] {
    NX_HOLD    = 2'd0,
    NX_SHIFT   = 2'd1,
    NX_CLEAR   = 2'd2,
    NX_RECOVER = 2'd3
  } nx_sel_e;

endpackage

// File: rtl/johnson_next_state.sv
module johnson_next_state
  import johnson_pkg::*;
#(
  parameter int STAGES = 4
) (
  input  logic [STAGES-1:0] cur_i,
  input  logic              en_i,
  input  logic              clr_i,
  output logic [STAGES-1:0] nxt_o,
  output logic              valid_o
);

  localparam int EDGES = STAGES - 1;

  logic [EDGES-1:0]  diff;
  logic [STAGES-1:0] shifted;
  nx_sel_e           sel;

  // A pattern on the cycle has at most one boundary between neighbours.
  assign diff    = cur_i[STAGES-1:1] ^ cur_i[STAGES-2:0];
  assign valid_o = ((diff & (diff - EDGES'(1))) == '0);

  // Switched tail: inverted last stage enters the first stage.
  assign shifted = {cur_i[STAGES-2:0], ~cur_i[STAGES-1]};

  always_comb begin
    if (clr_i)         sel = NX_CLEAR;
    else if (!en_i)    sel = NX_HOLD;
    else if (!valid_o) sel = NX_RECOVER;
    else               sel = NX_SHIFT;
  end

  always_comb begin
    unique case (sel)
      NX_HOLD:  nxt_o = cur_i;
      NX_SHIFT: nxt_o = shifted;
      default:  nxt_o = '0;
    endcase
  end

endmodule

// File: rtl/johnson_stage_reg.sv
module johnson_stage_reg #(
  parameter int STAGES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [STAGES-1:0] d_i,
  output logic [STAGES-1:0] q_o
);

  logic [STAGES-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else if (load_i) begin
      q_q <= d_i;
    end
  end

  assign q_o = q_q;

endmodule

// File: rtl/johnson_tick_decode.sv
module johnson_tick_decode #(
  parameter int STAGES = 4
) (
  input  logic [STAGES-1:0]   stage_i,
  input  logic                valid_i,
  output logic [2*STAGES-1:0] tick_o
);

  localparam int PHASES = 2 * STAGES;

  logic [PHASES-1:0] raw;

  // End-bit pair decodes: all zeros and all ones.
  assign raw[0]      = ~stage_i[0] & ~stage_i[STAGES-1];
  assign raw[STAGES] =  stage_i[0] &  stage_i[STAGES-1];

  // Adjacent-pair decodes locate the single boundary.
  for (genvar k = 1; k < STAGES; k++) begin : g_pair
    assign raw[k]        =  stage_i[k-1] & ~stage_i[k];
    assign raw[STAGES+k] = ~stage_i[k-1] &  stage_i[k];
  end

  assign tick_o = valid_i ? raw : '0;

endmodule

// File: rtl/johnson_timing_gen.sv
module johnson_timing_gen #(
  parameter int STAGES = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                clr_i,
  output logic [STAGES-1:0]   stage_o,
  output logic [2*STAGES-1:0] tick_o
);

  logic [STAGES-1:0] state_q;
  logic [STAGES-1:0] state_d;
  logic              state_valid;
  logic              load;

  assign load = en_i | clr_i;

  johnson_next_state #(.STAGES(STAGES)) u_next (
    .cur_i   (state_q),
    .en_i    (en_i),
    .clr_i   (clr_i),
    .nxt_o   (state_d),
    .valid_o (state_valid)
  );

  johnson_stage_reg #(.STAGES(STAGES)) u_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .d_i    (state_d),
    .q_o    (state_q)
  );

  johnson_tick_decode #(.STAGES(STAGES)) u_dec (
    .stage_i (state_q),
    .valid_i (state_valid),
    .tick_o  (tick_o)
  );

  assign stage_o = state_q;

endmodule

// File: rtl/johnson_timing_gen_chk.sv
module johnson_timing_gen_chk #(
  parameter int STAGES = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                en_i,
  input logic                clr_i,
  input logic [STAGES-1:0]   stage_o,
  input logic [2*STAGES-1:0] tick_o,
  input logic                valid
);

  // R1: switched-tail shift on an enabled step
  p_shift_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && valid) |=>
      (stage_o == {$past(stage_o[STAGES-2:0]), ~$past(stage_o[STAGES-1])}));

  // R4: one phase line per valid pattern
  p_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid |-> ($countones(tick_o) == 1));

  // R4: no phase line off the cycle
  p_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid |-> (tick_o == '0));

  // R5: hold while stalled
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> ($stable(stage_o) && $stable(tick_o)));

  // R6: clear wins over enable
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (stage_o == '0));

  // R8: misfit pattern is replaced by all-zero
  p_recover_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !valid) |=> (stage_o == '0));

endmodule

bind johnson_timing_gen johnson_timing_gen_chk #(.STAGES(STAGES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .clr_i   (clr_i),
  .stage_o (stage_o),
  .tick_o  (tick_o),
  .valid   (state_valid)
);

// File: tb/johnson_timing_gen_tb_top.sv
`timescale 1ns/1ps
module johnson_timing_gen_tb_top;

  localparam int N  = 4;
  localparam int NP = 2 * N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic clr = 1'b0;
  logic [N-1:0]  stage;
  logic [NP-1:0] tick;

  // Standalone next-state logic to reach patterns off the cycle.
  logic [N-1:0] rec_cur = '0;
  logic         rec_en = 1'b0;
  logic         rec_clr = 1'b0;
  logic [N-1:0] rec_nxt;
  logic         rec_valid;

  int compared = 0;
  int mismatched = 0;
  int model_k = 0;
  bit done = 1'b0;

  typedef struct {
    logic [N-1:0]  st;
    logic [NP-1:0] tk;
    string         req;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  johnson_timing_gen #(.STAGES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clr_i(clr),
    .stage_o(stage), .tick_o(tick)
  );

  johnson_next_state #(.STAGES(N)) rec_i (
    .cur_i(rec_cur), .en_i(rec_en), .clr_i(rec_clr),
    .nxt_o(rec_nxt), .valid_o(rec_valid)
  );

  function automatic logic [N-1:0] vec_of(int k);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) begin
      if (k <= N) v[i] = (i < k);
      else        v[i] = (i >= k - N);
    end
    return v;
  endfunction

  function automatic logic [NP-1:0] tick_of(int k);
    logic [NP-1:0] t;
    t = '0;
    t[k] = 1'b1;
    return t;
  endfunction

  task automatic check(string req, logic [NP-1:0] act, logic [NP-1:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Driver: applies one clock of stimulus and queues the expected result.
  task automatic drive(logic e, logic c, string req);
    exp_t x;
    @(negedge clk);
    en  = e;
    clr = c;
    if (c)      model_k = 0;
    else if (e) model_k = (model_k + 1) % NP;
    x.st  = vec_of(model_k);
    x.tk  = tick_of(model_k);
    x.req = req;
    sb_q.push_back(x);
  endtask

  // Monitor: compares after each edge, away from the edge itself.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t x;
      x = sb_q.pop_front();
      check({x.req, " stage"}, NP'(stage), NP'(x.st));
      check({x.req, " tick"}, tick, x.tk);
    end
  end

  initial begin
    #(5.0 * 200000);
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int nvalid;
    // R7: reset state with no clock edge yet
    #1;
    check("R7 stage", NP'(stage), '0);
    check("R7 tick", tick, NP'(1));

    // R9, R8: every pattern through the next-state logic
    nvalid = 0;
    for (int v = 0; v < (1 << N); v++) begin
      int kk;
      kk = -1;
      for (int k = 0; k < NP; k++) if (vec_of(k) == N'(v)) kk = k;
      rec_cur = N'(v);
      rec_clr = 1'b0;
      rec_en = 1'b1;
      #1;
      check("R9 valid flag", NP'(rec_valid), NP'(kk >= 0));
      if (rec_valid) nvalid++;
      if (kk >= 0) check("R1 next", NP'(rec_nxt), NP'(vec_of((kk + 1) % NP)));
      else         check("R8 recover", NP'(rec_nxt), '0);
      rec_en = 1'b0;
      #1;
      check("R8 hold when stalled", NP'(rec_nxt), NP'(v));
    end
    check("R9 valid count", NP'(nvalid), NP'(NP));

    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R3 R4: two full cycles
    for (int i = 0; i < 2 * NP; i++) drive(1'b1, 1'b0, "R2 R3 step");
    // R5: stall at each phase
    for (int i = 0; i < NP; i++) begin
      drive(1'b1, 1'b0, "R1 step");
      drive(1'b0, 1'b0, "R5 stall");
      drive(1'b0, 1'b0, "R5 stall");
    end
    // R6: clear mid-cycle, with and without enable
    drive(1'b1, 1'b0, "R2 step");
    drive(1'b1, 1'b0, "R2 step");
    drive(1'b1, 1'b1, "R6 clear with enable");
    drive(1'b1, 1'b0, "R4 step");
    drive(1'b1, 1'b0, "R4 step");
    drive(1'b0, 1'b1, "R6 clear no enable");
    drive(1'b0, 1'b0, "R5 stall after clear");
    // Alternating enable
    for (int i = 0; i < 3 * NP; i++) drive(i[0], 1'b0, "R3 alternating");
    drive(1'b0, 1'b0, "R5 final");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule